// File: doc/BRIEF.md
# Program Trace Window Capture Controller

This block sits beside a processor that reports instruction-flow status on every clock. It gets a 3-bit flow code and a 2-bit flush code, plus a stream of external bus cycles tagged as program-trace cycles. The controller decides which status samples and which tagged addresses are stored in two circular capture buffers. It also works out the address where the captured trace window begins.

Two capture modes exist, selected by a pin that is sampled only while reset is held:

- **Back-trace mode** stores everything from the first clock after reset.
- **Window mode** waits for a synchronisation event on the flow code and stops at the next one.

The sync code 011 is also an ordinary report code, so the block tells the two apart by looking at the flow code of the previous clock.

In window mode the start address depends on the report that follows the sync event, combined with the first two tagged addresses. For a taken direct branch the controller asks an external lookup for the signed branch offset of the instruction one word before the first tagged address. It presents the start address once that offset returns. Software reads both buffers through index ports and uses the write pointers and wrap flags to find the oldest entry.

Top module: `trc_window_ctrl`

## Requirements
- R1: In back-trace mode (`mode_window_i` low during reset) a status sample is stored on every clock from the first clock after reset. The start address becomes valid and equals the first tagged address stored.
- R2: In window mode, nothing is stored before the first sync event. The status sample of the event clock is the first entry of the status buffer.
- R3: `vsync_evt_o` is high exactly when `vf_i` is 011 and the flow code on the previous clock was 000, 001 or 010. The clock right after reset has no previous code and never yields an event.
- R4: In window mode, storing stops after the clock of the second sync event, which is itself stored. After that clock `active_o` stays low and neither pointer moves.
- R5: A tagged address is stored only on a clock where `mark_valid_i` is high and a status sample is also being stored. This holds independently of the flow code value.
- R6: When the report after the starting sync event is 001, the start address is the first stored tagged address.
- R7: When that report is 110, `ofs_req_o` rises with `ofs_addr_o` equal to the first tagged address minus 4. It stays high until `ofs_valid_i`. On the next clock the start address is that value plus `ofs_data_i`, read as a two's-complement number.
- R8: When that report is 101, the start address is the second stored tagged address, and it is not valid before that address arrives.
- R9: Any other code in that report raises `start_err_o`, and `start_valid_o` stays low.
- R10: Each buffer writes at its write pointer, which steps by one and wraps from depth-1 to 0. The wrap flag sets on the first wrap and holds. A read index returns the stored entry, with the status entry packed as flow code in bits 4:2 and flush code in bits 1:0.
- R11: Changes of `mode_window_i` after reset have no effect on capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_window_i | input | 1 | 1 selects window mode, 0 back-trace; sampled in reset |
| vf_i | input | 3 | Instruction flow status code |
| vfls_i | input | 2 | Flush status code |
| mark_valid_i | input | 1 | A tagged program-trace bus cycle is present |
| mark_addr_i | input | 32 | Address of the tagged bus cycle |
| ofs_req_o | output | 1 | Branch-offset lookup request |
| ofs_addr_o | output | 32 | Address of the branch instruction to look up |
| ofs_valid_i | input | 1 | Lookup result valid |
| ofs_data_i | input | 32 | Signed branch offset |
| vsync_evt_o | output | 1 | Sync event detected on this clock |
| active_o | output | 1 | Capture running |
| stat_rd_idx_i | input | SPW | Status buffer read index |
| stat_rd_data_o | output | 5 | Status entry {flow, flush} |
| stat_wr_ptr_o | output | SPW | Status buffer write pointer |
| stat_wrapped_o | output | 1 | Status buffer has wrapped |
| addr_rd_idx_i | input | APW | Address buffer read index |
| addr_rd_data_o | output | 32 | Address entry |
| addr_wr_ptr_o | output | APW | Address buffer write pointer |
| addr_wrapped_o | output | 1 | Address buffer has wrapped |
| start_valid_o | output | 1 | Start address valid |
| start_err_o | output | 1 | Start report code not decodable |
| start_addr_o | output | 32 | Trace window start address |

## Verification
The assertions rely on a few assumptions about the inputs:
- The lookup side answers only while a request is pending.
- The mode pin matters only during reset.
- A tagged address arriving outside the capture window must simply be dropped.

The stimulus follows the first two assumptions. It raises `ofs_valid_i` only after observing `ofs_req_o`, and it toggles `mode_window_i` mid-run to show that the toggle is ignored. For the third, it deliberately presents tagged cycles and 011 codes both before the window opens and after it closes, so those clocks show that no store happens.

// File: rtl/trc_pkg.sv
`timescale 1ns/1ps
package trc_pkg;
    localparam int VF_W   = 3;
    localparam int VFLS_W = 2;
    localparam int ADDR_W = 32;
    localparam int STAT_W = VF_W + VFLS_W;

    localparam logic [VF_W-1:0] VF_IDLE   = 3'b000;
    localparam logic [VF_W-1:0] VF_SEQ    = 3'b001;
    localparam logic [VF_W-1:0] VF_SYNC   = 3'b011;
    localparam logic [VF_W-1:0] VF_BR_IND = 3'b101;
    localparam logic [VF_W-1:0] VF_BR_DIR = 3'b110;
    localparam logic [VF_W-1:0] VF_RST    = 3'b111;

    typedef enum logic [1:0] {CAP_WAIT, CAP_RUN, CAP_DONE} cap_state_e;
    typedef enum logic [1:0] {RES_COLLECT, RES_LOOKUP, RES_FINAL} res_state_e;
endpackage

// File: rtl/trc_vsync_det.sv
module trc_vsync_det
    import trc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [VF_W-1:0] vf_i,
    output logic            evt_o
);
    typedef struct packed {
        logic [VF_W-1:0] prev;
    } det_t;

    det_t det_d, det_q;

    always_comb begin
        det_d      = det_q;
        det_d.prev = vf_i;
        evt_o      = (vf_i == VF_SYNC) &&
                     (det_q.prev inside {3'b000, 3'b001, 3'b010});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) det_q <= '{prev: VF_RST};
        else        det_q <= det_d;
    end
endmodule

// File: rtl/trc_ring.sv
module trc_ring #(
    parameter  int W     = 8,
    parameter  int DEPTH = 16,
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [W-1:0]  wdata_i,
    input  logic [PW-1:0] rd_idx_i,
    output logic [W-1:0]  rd_data_o,
    output logic [PW-1:0] wr_ptr_o,
    output logic          wrapped_o
);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic          wrapped;
    } ring_t;

    ring_t        ring_d, ring_q;
    logic [W-1:0] mem [DEPTH];

    always_comb begin
        ring_d = ring_q;
        if (we_i) begin
            if (ring_q.ptr == LAST) begin
                ring_d.ptr     = '0;
                ring_d.wrapped = 1'b1;
            end else begin
                ring_d.ptr = ring_q.ptr + PW'(1);
            end
        end
        rd_data_o = mem[rd_idx_i];
        wr_ptr_o  = ring_q.ptr;
        wrapped_o = ring_q.wrapped;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ring_q <= '0;
        else        ring_q <= ring_d;
    end

    always_ff @(posedge clk) begin
        if (we_i) mem[ring_q.ptr] <= wdata_i;
    end
endmodule

// File: rtl/trc_start_calc.sv
module trc_start_calc
    import trc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              window_i,
    input  logic              stat_we_i,
    input  logic [VF_W-1:0]   vf_i,
    input  logic              addr_we_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              ofs_req_o,
    output logic [ADDR_W-1:0] ofs_addr_o,
    input  logic              ofs_valid_i,
    input  logic [ADDR_W-1:0] ofs_data_i,
    output logic              valid_o,
    output logic              err_o,
    output logic [ADDR_W-1:0] start_o
);
    typedef struct packed {
        res_state_e        st;
        logic [1:0]        n_st;
        logic [VF_W-1:0]   vf2;
        logic [1:0]        n_addr;
        logic [ADDR_W-1:0] t1;
        logic [ADDR_W-1:0] t2;
        logic [ADDR_W-1:0] start;
        logic              valid;
        logic              err;
    } res_t;

    res_t              res_d, res_q;
    logic [ADDR_W-1:0] pred;

    always_comb begin
        res_d = res_q;
        pred  = res_q.t1 - ADDR_W'(4);

        // first two status samples: only the second one is kept
        if (stat_we_i && res_q.n_st != 2'd2) begin
            if (res_q.n_st == 2'd1) res_d.vf2 = vf_i;
            res_d.n_st = res_q.n_st + 2'd1;
        end
        // first two tagged addresses
        if (addr_we_i && res_q.n_addr != 2'd2) begin
            if (res_q.n_addr == 2'd0) res_d.t1 = addr_i;
            else                      res_d.t2 = addr_i;
            res_d.n_addr = res_q.n_addr + 2'd1;
        end

        case (res_q.st)
            RES_COLLECT: begin
                if (!window_i) begin
                    if (res_q.n_addr != 2'd0) begin
                        res_d.start = res_q.t1;
                        res_d.valid = 1'b1;
                        res_d.st    = RES_FINAL;
                    end
                end else if (res_q.n_st == 2'd2) begin
                    case (res_q.vf2)
                        VF_SEQ: begin
                            if (res_q.n_addr != 2'd0) begin
                                res_d.start = res_q.t1;
                                res_d.valid = 1'b1;
                                res_d.st    = RES_FINAL;
                            end
                        end
                        VF_BR_IND: begin
                            if (res_q.n_addr == 2'd2) begin
                                res_d.start = res_q.t2;
                                res_d.valid = 1'b1;
                                res_d.st    = RES_FINAL;
                            end
                        end
                        VF_BR_DIR: begin
                            if (res_q.n_addr != 2'd0) res_d.st = RES_LOOKUP;
                        end
                        default: begin
                            res_d.err = 1'b1;
                            res_d.st  = RES_FINAL;
                        end
                    endcase
                end
            end
            RES_LOOKUP: begin
                if (ofs_valid_i) begin
                    res_d.start = pred + ofs_data_i;
                    res_d.valid = 1'b1;
                    res_d.st    = RES_FINAL;
                end
            end
            default: ;
        endcase

        ofs_req_o  = (res_q.st == RES_LOOKUP);
        ofs_addr_o = pred;
        valid_o    = res_q.valid;
        err_o      = res_q.err;
        start_o    = res_q.start;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '{st: RES_COLLECT, default: '0};
        else        res_q <= res_d;
    end
endmodule

// File: rtl/trc_window_ctrl.sv
module trc_window_ctrl
    import trc_pkg::*;
#(
    parameter  int STAT_DEPTH = 16,
    parameter  int ADDR_DEPTH = 16,
    localparam int SPW = (STAT_DEPTH > 1) ? $clog2(STAT_DEPTH) : 1,
    localparam int APW = (ADDR_DEPTH > 1) ? $clog2(ADDR_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_window_i,
    input  logic [VF_W-1:0]   vf_i,
    input  logic [VFLS_W-1:0] vfls_i,
    input  logic              mark_valid_i,
    input  logic [ADDR_W-1:0] mark_addr_i,
    output logic              ofs_req_o,
    output logic [ADDR_W-1:0] ofs_addr_o,
    input  logic              ofs_valid_i,
    input  logic [ADDR_W-1:0] ofs_data_i,
    output logic              vsync_evt_o,
    output logic              active_o,
    input  logic [SPW-1:0]    stat_rd_idx_i,
    output logic [STAT_W-1:0] stat_rd_data_o,
    output logic [SPW-1:0]    stat_wr_ptr_o,
    output logic              stat_wrapped_o,
    input  logic [APW-1:0]    addr_rd_idx_i,
    output logic [ADDR_W-1:0] addr_rd_data_o,
    output logic [APW-1:0]    addr_wr_ptr_o,
    output logic              addr_wrapped_o,
    output logic              start_valid_o,
    output logic              start_err_o,
    output logic [ADDR_W-1:0] start_addr_o
);
    typedef struct packed {
        cap_state_e st;
        logic       win;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic evt;
    logic cap_en;
    logic addr_we;
    logic cap_done;
    logic win_mode;

    trc_vsync_det u_det (
        .clk   (clk),
        .rst_n (rst_n),
        .vf_i  (vf_i),
        .evt_o (evt)
    );

    always_comb begin
        ctl_d  = ctl_q;
        cap_en = 1'b0;
        case (ctl_q.st)
            CAP_WAIT: begin
                if (evt) begin
                    cap_en   = 1'b1;
                    ctl_d.st = CAP_RUN;
                end
            end
            CAP_RUN: begin
                cap_en = 1'b1;
                if (evt && ctl_q.win) ctl_d.st = CAP_DONE;
            end
            default: ;
        endcase
        addr_we     = cap_en && mark_valid_i;
        active_o    = (ctl_q.st == CAP_RUN);
        cap_done    = (ctl_q.st == CAP_DONE);
        win_mode    = ctl_q.win;
        vsync_evt_o = evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '{st: mode_window_i ? CAP_WAIT : CAP_RUN, win: mode_window_i};
        else        ctl_q <= ctl_d;
    end

    trc_ring #(.W(STAT_W), .DEPTH(STAT_DEPTH)) u_stat_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (cap_en),
        .wdata_i   ({vf_i, vfls_i}),
        .rd_idx_i  (stat_rd_idx_i),
        .rd_data_o (stat_rd_data_o),
        .wr_ptr_o  (stat_wr_ptr_o),
        .wrapped_o (stat_wrapped_o)
    );

    trc_ring #(.W(ADDR_W), .DEPTH(ADDR_DEPTH)) u_addr_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (addr_we),
        .wdata_i   (mark_addr_i),
        .rd_idx_i  (addr_rd_idx_i),
        .rd_data_o (addr_rd_data_o),
        .wr_ptr_o  (addr_wr_ptr_o),
        .wrapped_o (addr_wrapped_o)
    );

    trc_start_calc u_start (
        .clk         (clk),
        .rst_n       (rst_n),
        .window_i    (win_mode),
        .stat_we_i   (cap_en),
        .vf_i        (vf_i),
        .addr_we_i   (addr_we),
        .addr_i      (mark_addr_i),
        .ofs_req_o   (ofs_req_o),
        .ofs_addr_o  (ofs_addr_o),
        .ofs_valid_i (ofs_valid_i),
        .ofs_data_i  (ofs_data_i),
        .valid_o     (start_valid_o),
        .err_o       (start_err_o),
        .start_o     (start_addr_o)
    );
endmodule

// File: rtl/trc_window_chk.sv
module trc_window_chk
    import trc_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              win,
    input logic [VF_W-1:0]   vf_i,
    input logic              evt,
    input logic              active,
    input logic              cap_done,
    input logic              stat_we,
    input logic              addr_we,
    input logic [PW-1:0]     stat_ptr,
    input logic              stat_wrapped,
    input logic              ofs_req,
    input logic              ofs_valid,
    input logic              start_valid,
    input logic              start_err,
    input logic [ADDR_W-1:0] start_addr
);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    p_evt_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> (vf_i == VF_SYNC));

    p_back_always_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !win |-> (active && stat_we));

    p_wait_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (win && !active && !cap_done && !evt) |-> (!stat_we && !addr_we));

    p_done_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cap_done |=> (cap_done && $stable(stat_ptr)));

    p_addr_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        addr_we |-> stat_we);

    p_ptr_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stat_we |=> (stat_ptr == (($past(stat_ptr) == LAST) ? '0 : $past(stat_ptr) + PW'(1))));

    p_ptr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_we |=> $stable(stat_ptr));

    p_wrap_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wrapped |=> stat_wrapped);

    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs_req && !ofs_valid) |=> ofs_req);

    p_err_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_valid && start_err));

    p_start_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_valid |=> (start_valid && $stable(start_addr)));

    p_mode_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(win));
endmodule

bind trc_window_ctrl trc_window_chk #(.DEPTH(STAT_DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .win          (win_mode),
    .vf_i         (vf_i),
    .evt          (vsync_evt_o),
    .active       (active_o),
    .cap_done     (cap_done),
    .stat_we      (cap_en),
    .addr_we      (addr_we),
    .stat_ptr     (stat_wr_ptr_o),
    .stat_wrapped (stat_wrapped_o),
    .ofs_req      (ofs_req_o),
    .ofs_valid    (ofs_valid_i),
    .start_valid  (start_valid_o),
    .start_err    (start_err_o),
    .start_addr   (start_addr_o)
);

// File: tb/sim_trc_window_ctrl.sv
`timescale 1ns/1ps
module sim_trc_window_ctrl;
    localparam int SD = 8;
    localparam int AD = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_window = 1'b0;
    logic [2:0]  vf = 3'b000;
    logic [1:0]  vfls = 2'b00;
    logic        mark_valid = 1'b0;
    logic [31:0] mark_addr = '0;
    logic        ofs_req;
    logic [31:0] ofs_addr;
    logic        ofs_valid = 1'b0;
    logic [31:0] ofs_data = '0;
    logic        vsync_evt;
    logic        active;
    logic [2:0]  stat_rd_idx = '0;
    logic [4:0]  stat_rd_data;
    logic [2:0]  stat_wr_ptr;
    logic        stat_wrapped;
    logic [1:0]  addr_rd_idx = '0;
    logic [31:0] addr_rd_data;
    logic [1:0]  addr_wr_ptr;
    logic        addr_wrapped;
    logic        start_valid;
    logic        start_err;
    logic [31:0] start_addr;

    int n_tests = 0;
    int n_fail  = 0;

    // reference model state
    logic [4:0]  stat_hist[$];
    logic [31:0] addr_hist[$];
    logic [2:0]  prev_m;
    bit          win_m, waiting_m, done_m;

    always #5 clk = ~clk;

    trc_window_ctrl #(.STAT_DEPTH(SD), .ADDR_DEPTH(AD)) u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .mode_window_i  (mode_window),
        .vf_i           (vf),
        .vfls_i         (vfls),
        .mark_valid_i   (mark_valid),
        .mark_addr_i    (mark_addr),
        .ofs_req_o      (ofs_req),
        .ofs_addr_o     (ofs_addr),
        .ofs_valid_i    (ofs_valid),
        .ofs_data_i     (ofs_data),
        .vsync_evt_o    (vsync_evt),
        .active_o       (active),
        .stat_rd_idx_i  (stat_rd_idx),
        .stat_rd_data_o (stat_rd_data),
        .stat_wr_ptr_o  (stat_wr_ptr),
        .stat_wrapped_o (stat_wrapped),
        .addr_rd_idx_i  (addr_rd_idx),
        .addr_rd_data_o (addr_rd_data),
        .addr_wr_ptr_o  (addr_wr_ptr),
        .addr_wrapped_o (addr_wrapped),
        .start_valid_o  (start_valid),
        .start_err_o    (start_err),
        .start_addr_o   (start_addr)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input bit win);
        rst_n       = 1'b0;
        mode_window = win;
        vf          = 3'b000;
        vfls        = 2'b00;
        mark_valid  = 1'b0;
        ofs_valid   = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        stat_hist.delete();
        addr_hist.delete();
        prev_m    = 3'b111;
        win_m     = win;
        waiting_m = win;
        done_m    = 1'b0;
        #1;
        chk("R10", "reset stat ptr", 32'(stat_wr_ptr), 32'd0);
        chk("R10", "reset stat wrapped", 32'(stat_wrapped), 32'd0);
        chk("R5", "reset addr ptr", 32'(addr_wr_ptr), 32'd0);
        chk(win ? "R2" : "R1", "reset active", 32'(active), 32'(!win));
        chk("R9", "reset start flags", {30'd0, start_valid, start_err}, 32'd0);
    endtask

    // one clock of stimulus; model update; compare after the edge
    task automatic step(input logic [2:0] v, input logic [1:0] fl,
                        input logic mv, input logic [31:0] ma);
        bit evt_m, cap_m, act_m;
        vf = v; vfls = fl; mark_valid = mv; mark_addr = ma;
        #1;
        evt_m  = (v == 3'b011) && (prev_m == 3'b000 || prev_m == 3'b001 || prev_m == 3'b010);
        prev_m = v;
        chk("R3", "sync event", 32'(vsync_evt), 32'(evt_m));
        cap_m = 1'b0;
        if (!win_m) cap_m = 1'b1;
        else if (waiting_m) begin
            if (evt_m) begin cap_m = 1'b1; waiting_m = 1'b0; end
        end else if (!done_m) begin
            cap_m = 1'b1;
            if (evt_m) done_m = 1'b1;
        end
        if (cap_m) begin
            stat_hist.push_back({v, fl});
            if (mv) addr_hist.push_back(ma);
        end
        act_m = !win_m || (!waiting_m && !done_m);
        @(posedge clk);
        #1;
        chk("R4", "active", 32'(active), 32'(act_m));
        chk("R10", "stat ptr", 32'(stat_wr_ptr), 32'(stat_hist.size() % SD));
        chk("R10", "stat wrapped", 32'(stat_wrapped), 32'(stat_hist.size() >= SD));
        chk("R5", "addr ptr", 32'(addr_wr_ptr), 32'(addr_hist.size() % AD));
        chk("R5", "addr wrapped", 32'(addr_wrapped), 32'(addr_hist.size() >= AD));
    endtask

    // read both buffers within the current clock period
    task automatic check_bufs();
        int sc = stat_hist.size();
        int ac = addr_hist.size();
        for (int j = 0; j < SD && j < sc; j++) begin
            stat_rd_idx = 3'(j);
            #0.5;
            chk("R10", "stat entry", 32'(stat_rd_data), 32'(stat_hist[j + SD * ((sc - 1 - j) / SD)]));
        end
        for (int j = 0; j < AD && j < ac; j++) begin
            addr_rd_idx = 2'(j);
            #0.5;
            chk("R5", "addr entry", addr_rd_data, addr_hist[j + AD * ((ac - 1 - j) / AD)]);
        end
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // ---- back-trace mode
        do_reset(1'b0);
        step(3'b001, 2'd1, 1'b0, 32'h0);
        step(3'b001, 2'd2, 1'b1, 32'h0000_1000);
        step(3'b011, 2'd0, 1'b0, 32'h0);           // event
        step(3'b011, 2'd1, 1'b0, 32'h0);           // 011 after 011: not an event
        mode_window = 1'b1;                          // R11: ignored
        step(3'b110, 2'd3, 1'b1, 32'h0000_1100);
        step(3'b101, 2'd0, 1'b1, 32'h0000_1204);
        step(3'b000, 2'd1, 1'b0, 32'h0);
        step(3'b011, 2'd2, 1'b1, 32'h0000_1300);   // event, capture continues
        step(3'b001, 2'd1, 1'b1, 32'h0000_1400);
        step(3'b010, 2'd0, 1'b0, 32'h0);
        step(3'b001, 2'd3, 1'b1, 32'h0000_1500);
        step(3'b000, 2'd2, 1'b0, 32'h0);
        chk("R11", "active after mode toggle", 32'(active), 32'd1);
        check_bufs();
        chk("R1", "back start valid", 32'(start_valid), 32'd1);
        chk("R1", "back start addr", start_addr, 32'h0000_1000);

        // ---- window mode, sequential start
        do_reset(1'b1);
        step(3'b011, 2'd0, 1'b1, 32'h0000_AAA0);   // no previous code: no event
        step(3'b100, 2'd0, 1'b0, 32'h0);
        step(3'b011, 2'd1, 1'b1, 32'h0000_BBB0);   // after 100: no event
        mode_window = 1'b0;                          // R11: ignored
        step(3'b010, 2'd0, 1'b0, 32'h0);
        chk("R2", "nothing stored before sync", 32'(stat_wr_ptr), 32'd0);
        chk("R2", "no address before sync", 32'(addr_wr_ptr), 32'd0);
        step(3'b011, 2'd2, 1'b0, 32'h0);           // first event
        step(3'b001, 2'd1, 1'b1, 32'h0000_2000);
        step(3'b001, 2'd0, 1'b1, 32'h0000_2040);
        step(3'b110, 2'd0, 1'b0, 32'h0);
        step(3'b000, 2'd3, 1'b0, 32'h0);
        step(3'b011, 2'd1, 1'b1, 32'h0000_2100);   // second event, stored
        step(3'b001, 2'd0, 1'b1, 32'h0000_2200);   // after stop: ignored
        step(3'b010, 2'd0, 1'b0, 32'h0);
        step(3'b011, 2'd0, 1'b1, 32'h0000_2300);
        chk("R4", "stopped stat ptr", 32'(stat_wr_ptr), 32'd6);
        chk("R4", "stopped addr ptr", 32'(addr_wr_ptr), 32'd3);
        chk("R11", "window kept after toggle", 32'(active), 32'd0);
        check_bufs();
        chk("R2", "first entry is sync", 32'(stat_hist[0]), {27'd0, 3'b011, 2'd2});
        chk("R6", "seq start valid", 32'(start_valid), 32'd1);
        chk("R6", "seq start addr", start_addr, 32'h0000_2000);
        chk("R6", "seq no error", 32'(start_err), 32'd0);

        // ---- window mode, direct branch start
        do_reset(1'b1);
        step(3'b000, 2'd0, 1'b0, 32'h0);
        step(3'b011, 2'd0, 1'b0, 32'h0);
        step(3'b110, 2'd0, 1'b1, 32'h0000_3004);
        step(3'b001, 2'd0, 1'b0, 32'h0);
        chk("R7", "lookup request", 32'(ofs_req), 32'd1);
        chk("R7", "lookup address", ofs_addr, 32'h0000_3000);
        step(3'b001, 2'd0, 1'b0, 32'h0);
        chk("R7", "request held", 32'(ofs_req), 32'd1);
        chk("R7", "no start before offset", 32'(start_valid), 32'd0);
        ofs_valid = 1'b1;
        ofs_data  = 32'hFFFF_FF00;
        step(3'b001, 2'd0, 1'b0, 32'h0);
        ofs_valid = 1'b0;
        chk("R7", "direct start valid", 32'(start_valid), 32'd1);
        chk("R7", "direct start addr", start_addr, 32'h0000_2F00);
        chk("R7", "request dropped", 32'(ofs_req), 32'd0);

        // ---- window mode, indirect branch start
        do_reset(1'b1);
        step(3'b001, 2'd0, 1'b0, 32'h0);
        step(3'b011, 2'd0, 1'b0, 32'h0);
        step(3'b101, 2'd0, 1'b1, 32'h0000_4000);
        step(3'b000, 2'd0, 1'b0, 32'h0);
        chk("R8", "waits for second address", 32'(start_valid), 32'd0);
        step(3'b000, 2'd0, 1'b1, 32'h0000_5550);
        step(3'b000, 2'd0, 1'b0, 32'h0);
        step(3'b000, 2'd0, 1'b0, 32'h0);
        chk("R8", "indirect start valid", 32'(start_valid), 32'd1);
        chk("R8", "indirect start addr", start_addr, 32'h0000_5550);

        // ---- window mode, undecodable start report
        do_reset(1'b1);
        step(3'b010, 2'd0, 1'b0, 32'h0);
        step(3'b011, 2'd0, 1'b0, 32'h0);
        step(3'b100, 2'd0, 1'b1, 32'h0000_6000);
        step(3'b000, 2'd0, 1'b0, 32'h0);
        step(3'b000, 2'd0, 1'b0, 32'h0);
        chk("R9", "error flag", 32'(start_err), 32'd1);
        chk("R9", "no valid start", 32'(start_valid), 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule